// File: doc/BRIEF.md
# Dual-Channel Serial LCD Driver Core

This block is the digital core of a serial-input LCD driver that can be chained with others. It holds two channels of `N` bits each. Every channel has a shift register that can move in either direction and a latch behind it. Serial data arrives on one port of a port pair, clocked in by the falling edges of a shift strobe. A falling edge of a latch strobe copies the register into the latch. For every one of the `2*N` display outputs, the block produces a 3-bit code. The code names the reference level that an analog switch stage outside the block connects to that output.

A scan-mode input changes how channel 2 works. It swaps the two strobes for channel 2 only and inverts the AC phase that channel 2 uses. Channel 2 then works as a backplane (scan-line) driver, and channel 1 stays a segment driver. The strobes, the AC signal and the serial inputs are asynchronous. Each passes through a synchronizer on the system clock. Each port of a pair has an enable flag, which lets a pad wrapper build a bidirectional pin from it.

Top module: `lcd_drv_core`

## Requirements
- R1: After synchronous reset, both latches hold zero. With the AC input low and scan mode low, every channel 1 code reads 4 and every channel 2 code reads 6.
- R2: When a channel's direction input is high, its right port is the serial input and its left port is the output: the left enable is 1 and the right enable is 0. When the direction input is low, the roles and the enables are the other way round.
- R3: Shift order depends on direction. With direction low, the bit shifted in first ends up at output N of the channel after N shifts. With direction high, it ends up at output 1. The output-role port always shows the bit that the next shift will push out of the far end, so one bit entered is seen there after exactly N shifts and is gone after N+1.
- R4: A latch changes only when its channel gets a latch event. Shift events and rising strobe edges leave the level bus unchanged.
- R5: With scan mode low, channel 2 shifts on falling edges of the shift strobe and latches on falling edges of the latch strobe, the same as channel 1.
- R6: With scan mode high, channel 2 shifts on falling edges of the latch strobe and latches on falling edges of the shift strobe. Channel 1 is not affected by the mode.
- R7: Channel 1 output codes: a latched 1 gives 1 when AC is high and 2 when AC is low. A latched 0 gives 3 when AC is high and 4 when AC is low.
- R8: Channel 2 output codes with scan mode low: a latched 1 gives 1 when AC is high and 2 when AC is low. A latched 0 gives 5 when AC is high and 6 when AC is low.
- R9: Channel 2 output codes with scan mode high use the inverted AC: a latched 1 gives 2 when AC is high and 1 when AC is low. A latched 0 gives 6 when AC is high and 5 when AC is low.
- R10: The 1-based output k takes bits [3k-1:3k-3] of `level_o`. Outputs 1..N belong to channel 1 and outputs N+1..2N belong to channel 2. After reset, every code stays in the range 1 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_stb_i | input | 1 | Shift strobe, active on its falling edge |
| latch_stb_i | input | 1 | Latch strobe, active on its falling edge |
| ac_i | input | 1 | AC-inversion phase |
| scan_mode_i | input | 1 | High: channel 2 becomes the scan-line driver |
| dir1_i | input | 1 | Channel 1 direction |
| dir2_i | input | 1 | Channel 2 direction |
| left1_i | input | 1 | Channel 1 left port, input path |
| right1_i | input | 1 | Channel 1 right port, input path |
| left2_i | input | 1 | Channel 2 left port, input path |
| right2_i | input | 1 | Channel 2 right port, input path |
| left1_o | output | 1 | Channel 1 left port, output path |
| right1_o | output | 1 | Channel 1 right port, output path |
| left2_o | output | 1 | Channel 2 left port, output path |
| right2_o | output | 1 | Channel 2 right port, output path |
| left1_oe | output | 1 | Channel 1 left port output enable |
| right1_oe | output | 1 | Channel 1 right port output enable |
| left2_oe | output | 1 | Channel 2 left port output enable |
| right2_oe | output | 1 | Channel 2 right port output enable |
| level_o | output | 2*N*3 | Packed reference-level codes, output 1 in the lowest bits |

## Verification
Scan mode is the hardest state to reach with the whole level bus known. In that mode every strobe edge shifts one channel and latches the other, so no single edge can load both latches cleanly. The stimulus therefore runs three phases. First, latch-strobe edges fill channel 2 while channel 1's latch takes throwaway values. Second, shift-strobe edges fill channel 1, and the last of them latches the finished channel 2 register. Third, one latch-strobe edge latches channel 1. This last edge moves channel 2's register by one bit but leaves its latch alone. The whole bus is then compared under both AC phases.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  localparam int unsigned LVL_W = 3;

  typedef enum logic [LVL_W-1:0] {
    LVL_OFF   = 3'd0,
    LVL_SEL_A = 3'd1,
    LVL_SEL_B = 3'd2,
    LVL_C1_A  = 3'd3,
    LVL_C1_B  = 3'd4,
    LVL_C2_A  = 3'd5,
    LVL_C2_B  = 3'd6
  } lvl_e;

  // Pick the reference level for one output. In scan mode, channel 2 runs on the opposite phase.
  function automatic lvl_e pick_level(input logic is_ch2, input logic scan_mode,
                                      input logic dbit, input logic ac);
    logic phase;
    phase = (is_ch2 && scan_mode) ? ~ac : ac;
    if (dbit)
      return phase ? LVL_SEL_A : LVL_SEL_B;
    else if (is_ch2)
      return phase ? LVL_C2_A : LVL_C2_B;
    else
      return phase ? LVL_C1_A : LVL_C1_B;
  endfunction

endpackage

// File: rtl/lcd_sync.sv
module lcd_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= RST_VAL;
    else     pipe[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= RST_VAL;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/lcd_fall_det.sv
module lcd_fall_det #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '1;
      fall_o <= '0;
    end else begin
      prev_q <= lvl_i;
      fall_o <= prev_q & ~lvl_i;
    end
  end

endmodule

// File: rtl/lcd_shift_chan.sv
module lcd_shift_chan #(
  parameter int unsigned N = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_i,
  input  logic         sin_left_i,
  input  logic         sin_right_i,
  input  logic         shift_en_i,
  input  logic         latch_en_i,
  output logic [N-1:0] latch_o,
  output logic         out_left_o,
  output logic         out_right_o,
  output logic         oe_left_o,
  output logic         oe_right_o
);

  logic [N-1:0] sr_q;
  logic         sin;

  // Direction high: data enters on the right and moves toward output 1.
  assign sin = dir_i ? sin_right_i : sin_left_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= '0;
      latch_o <= '0;
    end else begin
      if (shift_en_i) begin
        if (dir_i) sr_q <= {sin, sr_q[N-1:1]};
        else       sr_q <= {sr_q[N-2:0], sin};
      end
      if (latch_en_i) latch_o <= sr_q;
    end
  end

  assign out_left_o  = dir_i ? sr_q[0] : 1'b0;
  assign out_right_o = dir_i ? 1'b0 : sr_q[N-1];
  assign oe_left_o   = dir_i;
  assign oe_right_o  = ~dir_i;

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_drv_pkg::*;
#(
  parameter int unsigned N = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N-1:0]           lat1_i,
  input  logic [N-1:0]           lat2_i,
  input  logic                   ac_i,
  input  logic                   scan_mode_i,
  output logic [2*N*LVL_W-1:0]   lvl_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_o <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        lvl_o[k*LVL_W +: LVL_W]     <= pick_level(1'b0, scan_mode_i, lat1_i[k], ac_i);
        lvl_o[(N+k)*LVL_W +: LVL_W] <= pick_level(1'b1, scan_mode_i, lat2_i[k], ac_i);
      end
    end
  end

endmodule

// File: rtl/lcd_drv_core.sv
module lcd_drv_core
  import lcd_drv_pkg::*;
#(
  parameter int unsigned N           = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_stb_i,
  input  logic                 latch_stb_i,
  input  logic                 ac_i,
  input  logic                 scan_mode_i,
  input  logic                 dir1_i,
  input  logic                 dir2_i,
  input  logic                 left1_i,
  input  logic                 right1_i,
  input  logic                 left2_i,
  input  logic                 right2_i,
  output logic                 left1_o,
  output logic                 right1_o,
  output logic                 left2_o,
  output logic                 right2_o,
  output logic                 left1_oe,
  output logic                 right1_oe,
  output logic                 left2_oe,
  output logic                 right2_oe,
  output logic [2*N*LVL_W-1:0] level_o
);

  localparam int unsigned CTRL_W = 3;
  localparam int unsigned DATA_W = 4;

  logic [CTRL_W-1:0] ctrl_s;
  logic [DATA_W-1:0] data_s;
  logic [1:0]        falls;
  logic              sh_fall, la_fall;
  logic              sh1_en, la1_en, sh2_en, la2_en;
  logic [N-1:0]      latch1, latch2;

  // Strobes rest high; AC rests low.
  lcd_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_ctrl_sync (
    .clk (clk), .rst (rst),
    .d_i ({shift_stb_i, latch_stb_i, ac_i}),
    .q_o (ctrl_s)
  );

  lcd_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
    .clk (clk), .rst (rst),
    .d_i ({left1_i, right1_i, left2_i, right2_i}),
    .q_o (data_s)
  );

  lcd_fall_det #(.W(2)) u_fall (
    .clk (clk), .rst (rst),
    .lvl_i (ctrl_s[2:1]),
    .fall_o (falls)
  );

  assign sh_fall = falls[1];
  assign la_fall = falls[0];

  // Channel 1 always uses the strobes as given. In scan mode, channel 2 uses them swapped.
  assign sh1_en = sh_fall;
  assign la1_en = la_fall;
  assign sh2_en = scan_mode_i ? la_fall : sh_fall;
  assign la2_en = scan_mode_i ? sh_fall : la_fall;

  lcd_shift_chan #(.N(N)) u_ch1 (
    .clk (clk), .rst (rst), .dir_i (dir1_i),
    .sin_left_i (data_s[3]), .sin_right_i (data_s[2]),
    .shift_en_i (sh1_en), .latch_en_i (la1_en),
    .latch_o (latch1),
    .out_left_o (left1_o), .out_right_o (right1_o),
    .oe_left_o (left1_oe), .oe_right_o (right1_oe)
  );

  lcd_shift_chan #(.N(N)) u_ch2 (
    .clk (clk), .rst (rst), .dir_i (dir2_i),
    .sin_left_i (data_s[1]), .sin_right_i (data_s[0]),
    .shift_en_i (sh2_en), .latch_en_i (la2_en),
    .latch_o (latch2),
    .out_left_o (left2_o), .out_right_o (right2_o),
    .oe_left_o (left2_oe), .oe_right_o (right2_oe)
  );

  lcd_level_map #(.N(N)) u_map (
    .clk (clk), .rst (rst),
    .lat1_i (latch1), .lat2_i (latch2),
    .ac_i (ctrl_s[0]), .scan_mode_i (scan_mode_i),
    .lvl_o (level_o)
  );

endmodule

// File: rtl/lcd_drv_core_chk.sv
module lcd_drv_core_chk #(
  parameter int unsigned N = 20
) (
  input logic           clk,
  input logic           rst,
  input logic           mode,
  input logic           sh_fall,
  input logic           la_fall,
  input logic           sh1_en,
  input logic           la1_en,
  input logic           sh2_en,
  input logic           la2_en,
  input logic [N-1:0]   latch1,
  input logic [N-1:0]   latch2,
  input logic [2*N*3-1:0] level
);

  assert_hold1_R4: assert property (@(posedge clk) disable iff (rst)
    !la1_en |=> $stable(latch1));

  assert_hold2_R4: assert property (@(posedge clk) disable iff (rst)
    !la2_en |=> $stable(latch2));

  assert_follow_R5: assert property (@(posedge clk) disable iff (rst)
    !mode |-> (sh2_en == sh1_en && la2_en == la1_en));

  assert_swap_R6: assert property (@(posedge clk) disable iff (rst)
    mode |-> (sh2_en == la_fall && la2_en == sh_fall));

  for (genvar k = 0; k < N; k++) begin : g_out
    assert_ch1_R7: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ((level[k*3 +: 3] inside {3'd1, 3'd2, 3'd3, 3'd4}) &&
                ((level[k*3 +: 3] <= 3'd2) == $past(latch1[k]))));

    assert_ch2_R8: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ((level[(N+k)*3 +: 3] inside {3'd1, 3'd2, 3'd5, 3'd6}) &&
                ((level[(N+k)*3 +: 3] <= 3'd2) == $past(latch2[k]))));
  end

endmodule

bind lcd_drv_core lcd_drv_core_chk #(.N(N)) u_chk (
  .clk (clk), .rst (rst), .mode (scan_mode_i),
  .sh_fall (sh_fall), .la_fall (la_fall),
  .sh1_en (sh1_en), .la1_en (la1_en), .sh2_en (sh2_en), .la2_en (la2_en),
  .latch1 (latch1), .latch2 (latch2), .level (level_o)
);

// File: tb/sim_lcd_drv_core.sv
module sim_lcd_drv_core;

  localparam int N  = 20;
  localparam int BW = 2*N*3;
  localparam int NV = 6;

  // Fields, from the top bit down: scan mode, ac, dir1, dir2, d1[19:0], d2[19:0]
  localparam logic [43:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 20'hA5C3F, 20'h0F0F1},
    {1'b0, 1'b0, 1'b1, 1'b1, 20'h12345, 20'hFEDCB},
    {1'b1, 1'b1, 1'b0, 1'b1, 20'h80001, 20'h00010},
    {1'b1, 1'b0, 1'b1, 1'b0, 20'hFFFFF, 20'h00000},
    {1'b0, 1'b1, 1'b1, 1'b0, 20'h00000, 20'hFFFFF},
    {1'b1, 1'b1, 1'b1, 1'b1, 20'h5AAAA, 20'h40000}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic shift_stb = 1'b1, latch_stb = 1'b1, ac = 1'b0, mode = 1'b0;
  logic dir1 = 1'b0, dir2 = 1'b0;
  logic l1i = 1'b0, r1i = 1'b0, l2i = 1'b0, r2i = 1'b0;
  logic l1o, r1o, l2o, r2o, l1e, r1e, l2e, r2e;
  logic [BW-1:0] level;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  lcd_drv_core #(.N(N)) u0 (
    .clk (clk), .rst (rst), .shift_stb_i (shift_stb), .latch_stb_i (latch_stb),
    .ac_i (ac), .scan_mode_i (mode), .dir1_i (dir1), .dir2_i (dir2),
    .left1_i (l1i), .right1_i (r1i), .left2_i (l2i), .right2_i (r2i),
    .left1_o (l1o), .right1_o (r1o), .left2_o (l2o), .right2_o (r2o),
    .left1_oe (l1e), .right1_oe (r1e), .left2_oe (l2e), .right2_oe (r2e),
    .level_o (level)
  );

  function automatic logic [2:0] exp_code(input logic ch2, input logic m,
                                          input logic b, input logic a);
    if (!ch2) return b ? (a ? 3'd1 : 3'd2) : (a ? 3'd3 : 3'd4);    // R7
    if (!m)   return b ? (a ? 3'd1 : 3'd2) : (a ? 3'd5 : 3'd6);    // R8
    return b ? (a ? 3'd2 : 3'd1) : (a ? 3'd6 : 3'd5);              // R9
  endfunction

  function automatic logic [BW-1:0] exp_bus(input logic m, input logic a,
                                            input logic [N-1:0] d1, input logic [N-1:0] d2);
    logic [BW-1:0] r;
    r = '0;
    for (int k = 0; k < N; k++) begin
      r[k*3 +: 3]     = exp_code(1'b0, m, d1[k], a);
      r[(N+k)*3 +: 3] = exp_code(1'b1, m, d2[k], a);
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ser(input int ch, input logic b);
    if (ch == 1) begin
      if (dir1) begin r1i = b; l1i = ~b; end
      else      begin l1i = b; r1i = ~b; end
    end else begin
      if (dir2) begin r2i = b; l2i = ~b; end
      else      begin l2i = b; r2i = ~b; end
    end
  endtask

  task automatic pulse(input logic is_latch);
    clks(4);
    if (is_latch) latch_stb = 1'b0; else shift_stb = 1'b0;
    clks(6);
    if (is_latch) latch_stb = 1'b1; else shift_stb = 1'b1;
    clks(6);
  endtask

  // Bit for position p is fed at step i so that it ends up at p (R3).
  function automatic int pos_of(input logic d, input int i);
    return d ? i : N-1-i;
  endfunction

  task automatic load(input logic m, input logic [N-1:0] d1, input logic [N-1:0] d2);
    if (!m) begin
      for (int i = 0; i < N; i++) begin
        set_ser(1, d1[pos_of(dir1, i)]);
        set_ser(2, d2[pos_of(dir2, i)]);
        pulse(1'b0);
      end
      pulse(1'b1);
    end else begin
      for (int i = 0; i < N; i++) begin
        set_ser(2, d2[pos_of(dir2, i)]);
        pulse(1'b1);
      end
      for (int i = 0; i < N; i++) begin
        set_ser(1, d1[pos_of(dir1, i)]);
        pulse(1'b0);
      end
      pulse(1'b1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [BW-1:0] snap;
    clks(5);
    rst = 1'b0;
    clks(4);
    chk(level === exp_bus(1'b0, 1'b0, '0, '0), "R1 reset levels", level,
        exp_bus(1'b0, 1'b0, '0, '0));

    for (int v = 0; v < NV; v++) begin
      logic m, a;
      logic [N-1:0] d1, d2;
      {m, a, dir1, dir2, d1, d2} = VEC[v];
      mode = m;
      ac   = a;
      clks(2);
      chk({l1e, r1e, l2e, r2e} === {dir1, ~dir1, dir2, ~dir2}, "R2 enables",
          BW'({l1e, r1e, l2e, r2e}), BW'({dir1, ~dir1, dir2, ~dir2}));
      load(m, d1, d2);
      clks(8);
      chk(level === exp_bus(m, a, d1, d2), m ? "R6 R9 R10 scan bus" : "R5 R8 R10 seg bus",
          level, exp_bus(m, a, d1, d2));
      ac = ~a;
      clks(8);
      chk(level === exp_bus(m, ~a, d1, d2), "R7 R8 R9 other phase",
          level, exp_bus(m, ~a, d1, d2));
      if (dir1) chk(l1o === d1[0] && r1o === 1'b0, "R3 ch1 out left",
                    BW'({l1o, r1o}), BW'({d1[0], 1'b0}));
      else      chk(r1o === d1[N-1] && l1o === 1'b0, "R3 ch1 out right",
                    BW'({l1o, r1o}), BW'({1'b0, d1[N-1]}));
      if (!m) begin
        if (dir2) chk(l2o === d2[0], "R3 ch2 out left", BW'(l2o), BW'(d2[0]));
        else      chk(r2o === d2[N-1], "R3 ch2 out right", BW'(r2o), BW'(d2[N-1]));
      end
    end

    // R4: shifting new data without a latch edge leaves the bus unchanged
    mode = 1'b0;
    dir1 = 1'b0;
    dir2 = 1'b1;
    clks(4);
    snap = level;
    for (int i = 0; i < 5; i++) begin
      set_ser(1, 1'b1);
      set_ser(2, 1'b1);
      pulse(1'b0);
    end
    clks(8);
    chk(level === snap, "R4 shift without latch", level, snap);

    // R3 cascade: a single 1 reaches the right port after N shifts and is gone after N+1
    set_ser(1, 1'b1);
    pulse(1'b0);
    for (int i = 1; i < N; i++) begin
      set_ser(1, 1'b0);
      pulse(1'b0);
    end
    chk(r1o === 1'b1, "R3 cascade after N", BW'(r1o), BW'(1'b1));
    pulse(1'b0);
    chk(r1o === 1'b0, "R3 cascade after N+1", BW'(r1o), BW'(1'b0));

    // R6: in scan mode, a shift edge alone latches channel 2 and leaves channel 1 latched as before
    mode = 1'b1;
    ac   = 1'b1;
    clks(8);
    snap = level;
    pulse(1'b0);
    clks(8);
    chk(level[N*3-1:0] === snap[N*3-1:0], "R6 ch1 unaffected by shift",
        level, snap);

    // R1: reset again clears the latched content
    rst = 1'b1;
    clks(3);
    rst  = 1'b0;
    mode = 1'b0;
    ac   = 1'b0;
    clks(8);
    chk(level === exp_bus(1'b0, 1'b0, '0, '0), "R1 second reset", level,
        exp_bus(1'b0, 1'b0, '0, '0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule